// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

This block is a bank of general-purpose pins behind a 32-bit register port. Each pin is configured on its own as a general input, a general output, or an interrupt input. Pin inputs pass through a two-flop synchroniser. The synchronised value can be read back. It also feeds a detector that works per pin in level or edge mode. Each pin has its own polarity select, and a both-edge option ignores polarity.

Edge events are latched in a status register and cleared by writing ones to a clear register. Level-mode status follows the synchronised pin level after the polarity select is applied. A per-pin enable mask, with a disable-only write port and a separate enable-only write port, selects which status bits drive the single combined interrupt line. Software writes registers with a one-cycle strobe. Read data is returned combinationally from the address.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, `pin_oe` is 0 and `irq` is 0.
- R2: Offsets 0x00 (mode: 1 = interrupt input), 0x04 (direction: 1 = output), 0x08 (output data), 0x20 (polarity), 0x24 (edge select: 1 = edge), 0x28 (filter enable, storage only) and 0x4C (both-edge) read back the value last written.
- R3: `pin_oe` bit equals direction bit AND NOT mode bit, so an interrupt-mode pin is always an input.
- R4: `pin_out` equals the output data register, and that register keeps its value when the direction changes.
- R5: Offset 0x0C reads the pin inputs two clock edges after they change.
- R6: For a pin with mode 1 and edge select 0, status (offset 0x10) equals the synchronised level XOR the polarity bit, so polarity 0 is active-high and polarity 1 is active-low.
- R7: For a pin with mode 1 and edge select 1, polarity 0 latches a status bit on a rising edge and polarity 1 latches it on a falling edge. The bit stays set until a 1 is written to that bit at offset 0x14. Writing 0 there has no effect.
- R8: With both-edge 1 on an edge-mode pin, both rising and falling edges latch status, regardless of polarity.
- R9: A pin with mode 0 never shows a status bit, whatever its input does.
- R10: Writing offset 0x18 clears each mask bit whose data bit is 0 and leaves the others. Writing 1 to a bit at offset 0x1C sets that mask bit. Offset 0x18 reads the mask. Offsets 0x14 and 0x1C read 0.
- R11: `irq` is 1 exactly when status AND mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | AW | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pin_in | input | NPINS | Asynchronous pin inputs |
| pin_out | output | NPINS | Output drive value |
| pin_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
On every cycle, the assertions check the following:
- A mask write can only clear bits.
- An unmask write sets every written bit.
- A status latch never sets on a pin outside edge interrupt mode.
- The output data holds between writes to its offset.
- Output enables never reach interrupt-mode pins.
- `irq` never rises without a mask bit set.

Only the bench scenarios show that the following are correct:
- The polarity and both-edge selection.
- The two-cycle synchroniser delay.
- Edge latching across the end of a pulse.
- The no-effect behaviour of zero bits written to the clear register.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPINS = 32,
  parameter int AW    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam logic [AW-1:0] A_MODE = AW'(7'h00);
  localparam logic [AW-1:0] A_DIR  = AW'(7'h04);
  localparam logic [AW-1:0] A_OUT  = AW'(7'h08);
  localparam logic [AW-1:0] A_IN   = AW'(7'h0C);
  localparam logic [AW-1:0] A_STAT = AW'(7'h10);
  localparam logic [AW-1:0] A_CLR  = AW'(7'h14);
  localparam logic [AW-1:0] A_MASK = AW'(7'h18);
  localparam logic [AW-1:0] A_UNMK = AW'(7'h1C);
  localparam logic [AW-1:0] A_POL  = AW'(7'h20);
  localparam logic [AW-1:0] A_EDGE = AW'(7'h24);
  localparam logic [AW-1:0] A_FILT = AW'(7'h28);
  localparam logic [AW-1:0] A_BOTH = AW'(7'h4C);

  logic [NPINS-1:0] mode_q, dir_q, out_q, mask_q, pol_q, edg_q, filt_q, both_q;
  logic [NPINS-1:0] sync1_q, sync2_q, prev_q, edge_lat;
  logic [NPINS-1:0] wd, rise, fall, hit, clr, status;
  logic [NPINS-1:0] rsel;

  assign wd   = reg_wdata[NPINS-1:0];
  assign rise = sync2_q & ~prev_q;
  assign fall = ~sync2_q & prev_q;
  assign hit  = mode_q & edg_q & ((both_q & (rise | fall)) |
                                  (~both_q & ~pol_q & rise) |
                                  (~both_q & pol_q & fall));
  assign clr  = (reg_wr && reg_addr == A_CLR) ? wd : '0;

  assign status  = mode_q & ((edg_q & edge_lat) | (~edg_q & (sync2_q ^ pol_q)));
  assign irq     = |(status & mask_q);
  assign pin_out = out_q;
  assign pin_oe  = dir_q & ~mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q  <= '0;
      sync2_q  <= '0;
      prev_q   <= '0;
      edge_lat <= '0;
    end else begin
      sync1_q  <= pin_in;
      sync2_q  <= sync1_q;
      prev_q   <= sync2_q;
      edge_lat <= (edge_lat & ~clr) | hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      mask_q <= '0;
      pol_q  <= '0;
      edg_q  <= '0;
      filt_q <= '0;
      both_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_MODE:  mode_q <= wd;
        A_DIR:   dir_q  <= wd;
        A_OUT:   out_q  <= wd;
        A_MASK:  mask_q <= mask_q & wd;
        A_UNMK:  mask_q <= mask_q | wd;
        A_POL:   pol_q  <= wd;
        A_EDGE:  edg_q  <= wd;
        A_FILT:  filt_q <= wd;
        A_BOTH:  both_q <= wd;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  rsel = mode_q;
      A_DIR:   rsel = dir_q;
      A_OUT:   rsel = out_q;
      A_IN:    rsel = sync2_q;
      A_STAT:  rsel = status;
      A_MASK:  rsel = mask_q;
      A_POL:   rsel = pol_q;
      A_EDGE:  rsel = edg_q;
      A_FILT:  rsel = filt_q;
      A_BOTH:  rsel = both_q;
      default: rsel = '0;
    endcase
  end
  assign reg_rdata = 32'(rsel);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [AW-1:0]    reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] mode_q,
  input logic [NPINS-1:0] edg_q,
  input logic [NPINS-1:0] edge_lat
);
  p_mask_only_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(7'h18)) |=> ((mask_q & ~$past(mask_q)) == '0));

  p_mask_keeps_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(7'h18)) |=>
      (((mask_q ^ $past(mask_q)) & $past(reg_wdata[NPINS-1:0])) == '0));

  p_unmask_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(7'h1C)) |=>
      ((mask_q & $past(reg_wdata[NPINS-1:0])) == $past(reg_wdata[NPINS-1:0])));

  p_latch_only_edge_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_lat & ~$past(edge_lat) & ~$past(mode_q & edg_q)) == '0));

  p_out_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == AW'(7'h08)) |=> $stable(pin_out));

  p_irq_pin_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & mode_q) == '0);

  p_irq_needs_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .mask_q(mask_q), .mode_q(mode_q), .edg_q(edg_q), .edge_lat(edge_lat)
);

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
  localparam int NPINS = 32;
  localparam int AW    = 7;

  logic clk = 0, rst_n = 0, reg_wr = 0, irq;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NPINS-1:0] pin_in = '0, pin_out, pin_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  gpio_irq_bank #(.NPINS(NPINS), .AW(AW)) dut (.*);

  always #5 clk = ~clk;

  // {addr, write data, expected read}
  localparam logic [70:0] VEC [9] = '{
    {7'h00, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    {7'h04, 32'h1234_5678, 32'h1234_5678},
    {7'h08, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {7'h20, 32'h0F0F_F0F0, 32'h0F0F_F0F0},
    {7'h24, 32'h3333_CCCC, 32'h3333_CCCC},
    {7'h28, 32'h5555_AAAA, 32'h5555_AAAA},
    {7'h4C, 32'h8001_0002, 32'h8001_0002},
    {7'h14, 32'hFFFF_FFFF, 32'h0000_0000},
    {7'h1C, 32'h0000_00F0, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; pin_in = '0;
    cyc(3); rst_n = 1; cyc(1);
  endtask

  initial begin
    logic [31:0] v;
    cyc(3); rst_n = 1; cyc(1);

    // R1 reset state
    for (int i = 0; i < 9; i++) begin
      rd(VEC[i][70:64], v);
      chk("R1 reset read", v, 32'h0);
    end
    rd(7'h18, v); chk("R1 reset mask", v, 32'h0);
    chk("R1 reset oe", pin_oe, 32'h0);
    chk("R1 reset irq", {31'h0, irq}, 32'h0);

    // R2 / R10 register table
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][70:64], VEC[i][63:32]);
      rd(VEC[i][70:64], v);
      chk("R2/R10 table", v, VEC[i][31:0]);
    end
    rd(7'h18, v); chk("R10 unmask via table", v, 32'h0000_00F0);

    // R3 R4 output path
    do_reset();
    wr(7'h08, 32'h0000_00A5);
    wr(7'h04, 32'h0000_00FF);
    chk("R3 oe", pin_oe, 32'h0000_00FF);
    chk("R4 out", pin_out, 32'h0000_00A5);
    wr(7'h00, 32'h0000_000F);
    chk("R3 irq mode forces input", pin_oe, 32'h0000_00F0);
    wr(7'h04, 32'h0);
    chk("R4 out kept after dir change", pin_out, 32'h0000_00A5);
    chk("R3 oe off", pin_oe, 32'h0);

    // R5 input sync
    do_reset();
    @(negedge clk); pin_in = 32'h1234_5678;
    cyc(1); rd(7'h0C, v); chk("R5 one edge not yet", v, 32'h0);
    cyc(1); rd(7'h0C, v); chk("R5 two edges", v, 32'h1234_5678);

    // R6 level, R11 irq
    do_reset();
    wr(7'h00, 32'h1);
    @(negedge clk); pin_in[0] = 1;
    cyc(2); rd(7'h10, v); chk("R6 active high", v & 32'h1, 32'h1);
    @(negedge clk); pin_in[0] = 0;
    cyc(2); rd(7'h10, v); chk("R6 level follows", v & 32'h1, 32'h0);
    wr(7'h20, 32'h1);
    rd(7'h10, v); chk("R6 active low", v & 32'h1, 32'h1);
    chk("R11 masked no irq", {31'h0, irq}, 32'h0);
    wr(7'h1C, 32'h1);
    chk("R11 irq on unmask", {31'h0, irq}, 32'h1);
    wr(7'h18, 32'hFFFF_FFFE);
    chk("R11 irq off after mask", {31'h0, irq}, 32'h0);

    // R7 edge
    wr(7'h00, 32'h0000_000F);
    wr(7'h24, 32'h0000_000E);
    @(negedge clk); pin_in[1] = 1;
    cyc(3); rd(7'h10, v); chk("R7 rising latched", v & 32'h2, 32'h2);
    @(negedge clk); pin_in[1] = 0;
    cyc(3); rd(7'h10, v); chk("R7 held after pulse", v & 32'h2, 32'h2);
    wr(7'h1C, 32'h2);
    chk("R11 irq from edge", {31'h0, irq}, 32'h1);
    wr(7'h14, 32'hFFFF_FFFD);
    rd(7'h10, v); chk("R7 zero clear no effect", v & 32'h2, 32'h2);
    wr(7'h14, 32'h2);
    rd(7'h10, v); chk("R7 cleared", v & 32'h2, 32'h0);
    chk("R11 irq drops", {31'h0, irq}, 32'h0);
    wr(7'h20, 32'h3);
    @(negedge clk); pin_in[1] = 1;
    cyc(3); rd(7'h10, v); chk("R7 falling ignores rise", v & 32'h2, 32'h0);
    @(negedge clk); pin_in[1] = 0;
    cyc(3); rd(7'h10, v); chk("R7 falling latched", v & 32'h2, 32'h2);

    // R8 both edges, polarity 1 set on pin 2
    wr(7'h20, 32'h7);
    wr(7'h4C, 32'h4);
    @(negedge clk); pin_in[2] = 1;
    cyc(3); rd(7'h10, v); chk("R8 rise with both", v & 32'h4, 32'h4);
    wr(7'h14, 32'h4);
    @(negedge clk); pin_in[2] = 0;
    cyc(3); rd(7'h10, v); chk("R8 fall with both", v & 32'h4, 32'h4);

    // R9 general-mode pin never reports
    wr(7'h00, 32'h0000_0007);
    wr(7'h24, 32'h0000_000E);
    @(negedge clk); pin_in[3] = 1;
    cyc(3); rd(7'h10, v); chk("R9 io pin rise", v & 32'h8, 32'h0);
    @(negedge clk); pin_in[3] = 0;
    cyc(3); rd(7'h10, v); chk("R9 io pin fall", v & 32'h8, 32'h0);

    // R10 mask semantics
    wr(7'h1C, 32'h0000_000C);
    rd(7'h18, v); chk("R10 unmask", v, 32'h0000_000E);
    wr(7'h18, 32'hFFFF_FFF7);
    rd(7'h18, v); chk("R10 mask clears zero bits", v, 32'h0000_0006);
    rd(7'h1C, v); chk("R10 unmask reads 0", v, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule